// File: doc/BRIEF.md
# Snoop Response Resolution Sequencer

This block runs the response side of one pending read on a split-transaction snooping bus. After a read request is accepted, the sequencer watches three wired-OR snoop lines: shared, dirty and inhibit. A cache that is still looking up its tags holds inhibit high. While inhibit is high the sequencer waits, even if memory already has the line ready. When inhibit drops, the dirty line decides the data source. If dirty is high, a cache owns a modified copy: memory is told to abort its fetch, and the sequencer waits for that cache to be ready. If dirty is low, memory supplies the line as soon as it is ready.

Once the source is known, the sequencer requests the response bus through a simple request/grant pair. It then drives a fixed data phase. The phase has one beat for each bus-width slice of the line (four beats for a 128-byte line on a 256-bit bus), followed by one turnaround cycle. Every beat carries the request tag and the snoop results, so responses may return in any order relative to their requests. The tag is released on the last beat. When a dirty cache supplies an ordinary read, memory takes the data in as a writeback, and other caches may take a copy. For an exclusive read, neither memory nor any other cache keeps the data.

States: IDLE (no request pending), SNOOP (waiting for inhibit to drop and the source to be known), WAIT_OWNER (dirty cache chosen, waiting for its cache_ready), ARB (bus_req high until bus_grant), DATA (beats on the response bus), TURN (one turnaround cycle). The transitions are:
- IDLE to SNOOP on req_valid.
- SNOOP to WAIT_OWNER when inhibit is low and dirty is high.
- SNOOP to ARB when inhibit and dirty are low and mem_ready is high.
- WAIT_OWNER to ARB on cache_ready.
- ARB to DATA on bus_grant.
- DATA to TURN on the last beat.
- TURN to IDLE always.

Top module: `snoop_rsp_seq`

## Requirements
- R1: After reset, busy, bus_req, rsp_valid, mem_abort and tag_release are all low.
- R2: While a request is in snoop and snp_inhibit is high, bus_req and mem_abort stay low, whatever mem_ready is.
- R3: In snoop with snp_inhibit low and snp_dirty high, mem_abort is high for exactly that one cycle. bus_req then stays low until the cycle after cache_ready is seen high, and the response source is the cache.
- R4: In snoop with snp_inhibit and snp_dirty low, mem_abort stays low. bus_req rises the cycle after mem_ready is seen high, and the response source is memory.
- R5: Once raised, bus_req stays high until the cycle bus_grant is seen. The first data beat appears in the following cycle.
- R6: A data phase is exactly 4 consecutive rsp_valid cycles with rsp_beat counting 0,1,2,3. One cycle with rsp_valid low and busy high follows, then busy falls.
- R7: On every beat, rsp_tag equals the accepted req_tag. rsp_src and rsp_dirty are 1 for a cache source and 0 for memory. rsp_shared is the OR of snp_shared over the snoop cycles.
- R8: tag_release is high only on beat 3, the last beat.
- R9: mem_sink is high on every beat when the source is a cache and the read is not exclusive, and low otherwise. grab_ok is high on every beat of a non-exclusive read and low for an exclusive read.
- R10: req_valid while busy is ignored: the tag on the bus does not change, and no new transaction starts after the turnaround.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New pending read accepted when idle |
| req_tag | input | TAG_W | Tag of the pending read |
| req_excl | input | 1 | Read is exclusive (read for ownership) |
| mem_ready | input | 1 | Memory has the line ready |
| snp_shared | input | 1 | Wired-OR shared line |
| snp_dirty | input | 1 | Wired-OR dirty line |
| snp_inhibit | input | 1 | Wired-OR inhibit line |
| cache_ready | input | 1 | Dirty owner cache ready to send |
| bus_grant | input | 1 | Response bus granted |
| busy | output | 1 | A transaction is in progress |
| bus_req | output | 1 | Response bus request |
| rsp_valid | output | 1 | Data beat on the response bus |
| rsp_tag | output | TAG_W | Tag driven with the response |
| rsp_src | output | 1 | Source: 1 cache, 0 memory |
| rsp_shared | output | 1 | Snoop result: shared |
| rsp_dirty | output | 1 | Snoop result: dirty |
| rsp_beat | output | BEAT_W | Beat index within the data phase |
| mem_abort | output | 1 | Memory cancels its response |
| mem_sink | output | 1 | Memory absorbs beats as a writeback |
| grab_ok | output | 1 | Other caches may take a copy |
| tag_release | output | 1 | Tag is freed on this beat |

## Verification
The assertions assume the environment drives req_valid only to start a transaction and keeps bus_grant low unless bus_req is high. They also assume snp_dirty is meaningful only once snp_inhibit is low. The bench enforces these assumptions in a single transaction task. That task raises bus_grant only during arbitration, holds dirty low while inhibit is high, and draws its random inhibit lengths, memory and cache delays, grant delays, tags and flags inside those limits. Directed cases cover memory becoming ready under inhibit, a zero-length snoop, an immediate grant, and an exclusive read from a dirty owner.

// File: rtl/snoop_rsp_seq_pkg.sv
`timescale 1ns/1ps
package snoop_rsp_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SNOOP,
        ST_WAIT_OWNER,
        ST_ARB,
        ST_DATA,
        ST_TURN
    } seq_state_e;

    typedef enum logic [1:0] {
        DEC_WAIT,
        DEC_MEM,
        DEC_CACHE
    } snoop_dec_e;
endpackage

// File: rtl/snoop_resolve.sv
`timescale 1ns/1ps
module snoop_resolve
    import snoop_rsp_seq_pkg::*;
(
    input  logic       inhibit,
    input  logic       dirty,
    input  logic       mem_ready,
    output snoop_dec_e dec
);
    // Inhibit masks everything; dirty beats memory; memory waits for ready.
    always_comb begin
        if (inhibit)
            dec = DEC_WAIT;
        else if (dirty)
            dec = DEC_CACHE;
        else if (mem_ready)
            dec = DEC_MEM;
        else
            dec = DEC_WAIT;
    end
endmodule

// File: rtl/beat_ctr.sv
`timescale 1ns/1ps
module beat_ctr #(
    parameter int BEATS  = 4,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [BEAT_W-1:0] cnt,
    output logic              last
);
    localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BEATS - 1);

    assign last = (cnt == LAST_IDX);

    always_ff @(posedge clk) begin
        if (!rst_n || !adv)
            cnt <= '0;
        else if (last)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/snoop_rsp_seq.sv
`timescale 1ns/1ps
module snoop_rsp_seq
    import snoop_rsp_seq_pkg::*;
#(
    parameter int TAG_W      = 3,
    parameter int LINE_BYTES = 128,
    parameter int BUS_BITS   = 256,
    parameter int BEATS      = (LINE_BYTES * 8) / BUS_BITS,
    parameter int BEAT_W     = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              req_excl,
    input  logic              mem_ready,
    input  logic              snp_shared,
    input  logic              snp_dirty,
    input  logic              snp_inhibit,
    input  logic              cache_ready,
    input  logic              bus_grant,
    output logic              busy,
    output logic              bus_req,
    output logic              rsp_valid,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_src,
    output logic              rsp_shared,
    output logic              rsp_dirty,
    output logic [BEAT_W-1:0] rsp_beat,
    output logic              mem_abort,
    output logic              mem_sink,
    output logic              grab_ok,
    output logic              tag_release
);
    seq_state_e        state, state_nx;
    snoop_dec_e        dec;
    logic [TAG_W-1:0]  tag_q;
    logic              excl_q;
    logic              shared_q;
    logic              src_q;
    logic [BEAT_W-1:0] beat;
    logic              beat_last;

    snoop_resolve u_resolve (
        .inhibit   (snp_inhibit),
        .dirty     (snp_dirty),
        .mem_ready (mem_ready),
        .dec       (dec)
    );

    beat_ctr #(.BEATS(BEATS), .BEAT_W(BEAT_W)) u_beats (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (state == ST_DATA),
        .cnt   (beat),
        .last  (beat_last)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (req_valid) state_nx = ST_SNOOP;
            ST_SNOOP: begin
                if (dec == DEC_CACHE)    state_nx = ST_WAIT_OWNER;
                else if (dec == DEC_MEM) state_nx = ST_ARB;
            end
            ST_WAIT_OWNER: if (cache_ready) state_nx = ST_ARB;
            ST_ARB:        if (bus_grant)   state_nx = ST_DATA;
            ST_DATA:       if (beat_last)   state_nx = ST_TURN;
            ST_TURN:       state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            tag_q    <= '0;
            excl_q   <= 1'b0;
            shared_q <= 1'b0;
            src_q    <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_valid) begin
                tag_q    <= req_tag;
                excl_q   <= req_excl;
                shared_q <= 1'b0;
                src_q    <= 1'b0;
            end
            if (state == ST_SNOOP) begin
                shared_q <= shared_q | snp_shared;
                if (dec == DEC_CACHE)
                    src_q <= 1'b1;
            end
        end
    end

    always_comb begin
        busy        = (state != ST_IDLE);
        bus_req     = (state == ST_ARB);
        rsp_valid   = 1'b0;
        rsp_tag     = '0;
        rsp_src     = 1'b0;
        rsp_shared  = 1'b0;
        rsp_dirty   = 1'b0;
        rsp_beat    = '0;
        mem_abort   = 1'b0;
        mem_sink    = 1'b0;
        grab_ok     = 1'b0;
        tag_release = 1'b0;
        unique case (state)
            ST_SNOOP: mem_abort = (dec == DEC_CACHE);
            ST_DATA: begin
                rsp_valid   = 1'b1;
                rsp_tag     = tag_q;
                rsp_src     = src_q;
                rsp_shared  = shared_q;
                rsp_dirty   = src_q;
                rsp_beat    = beat;
                mem_sink    = src_q && !excl_q;
                grab_ok     = !excl_q;
                tag_release = beat_last;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/snoop_rsp_seq_chk.sv
`timescale 1ns/1ps
module snoop_rsp_seq_chk
    import snoop_rsp_seq_pkg::*;
#(
    parameter int TAG_W  = 3,
    parameter int BEATS  = 4,
    parameter int BEAT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              snp_inhibit,
    input logic              bus_grant,
    input logic              busy,
    input logic              bus_req,
    input logic              rsp_valid,
    input logic [TAG_W-1:0]  rsp_tag,
    input logic              rsp_src,
    input logic [BEAT_W-1:0] rsp_beat,
    input logic              mem_abort,
    input logic              mem_sink,
    input logic              tag_release,
    input seq_state_e        state
);
    assert_inhibit_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SNOOP && snp_inhibit) |-> (!mem_abort && !bus_req));

    assert_abort_then_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_abort |=> !bus_req);

    assert_no_abort_in_arb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !mem_abort);

    assert_req_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_grant) |=> bus_req);

    assert_grant_to_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_grant) |=> (rsp_valid && rsp_beat == '0));

    assert_turnaround_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_beat == BEAT_W'(BEATS - 1)) |=> (!rsp_valid && busy));

    assert_tag_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(rsp_valid)) |-> $stable(rsp_tag));

    assert_release_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tag_release |-> (rsp_valid && rsp_beat == BEAT_W'(BEATS - 1)));

    assert_sink_from_cache_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_sink |-> (rsp_valid && rsp_src));
endmodule

bind snoop_rsp_seq snoop_rsp_seq_chk #(
    .TAG_W  (TAG_W),
    .BEATS  (BEATS),
    .BEAT_W (BEAT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .snp_inhibit (snp_inhibit),
    .bus_grant   (bus_grant),
    .busy        (busy),
    .bus_req     (bus_req),
    .rsp_valid   (rsp_valid),
    .rsp_tag     (rsp_tag),
    .rsp_src     (rsp_src),
    .rsp_beat    (rsp_beat),
    .mem_abort   (mem_abort),
    .mem_sink    (mem_sink),
    .tag_release (tag_release),
    .state       (state)
);

// File: tb/sim_snoop_rsp_seq.sv
`timescale 1ns/1ps
module sim_snoop_rsp_seq;
    localparam int TAG_W = 3;
    localparam int NBEAT = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic [TAG_W-1:0] req_tag = '0;
    logic             req_excl = 1'b0;
    logic             mem_ready = 1'b0;
    logic             snp_shared = 1'b0;
    logic             snp_dirty = 1'b0;
    logic             snp_inhibit = 1'b0;
    logic             cache_ready = 1'b0;
    logic             bus_grant = 1'b0;
    logic             busy, bus_req, rsp_valid, rsp_src, rsp_shared, rsp_dirty;
    logic [TAG_W-1:0] rsp_tag;
    logic [1:0]       rsp_beat;
    logic             mem_abort, mem_sink, grab_ok, tag_release;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    snoop_rsp_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
        .req_excl(req_excl), .mem_ready(mem_ready), .snp_shared(snp_shared),
        .snp_dirty(snp_dirty), .snp_inhibit(snp_inhibit), .cache_ready(cache_ready),
        .bus_grant(bus_grant), .busy(busy), .bus_req(bus_req), .rsp_valid(rsp_valid),
        .rsp_tag(rsp_tag), .rsp_src(rsp_src), .rsp_shared(rsp_shared),
        .rsp_dirty(rsp_dirty), .rsp_beat(rsp_beat), .mem_abort(mem_abort),
        .mem_sink(mem_sink), .grab_ok(grab_ok), .tag_release(tag_release)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic bit exp_sink(input bit from_cache, input bit excl);
        return from_cache && !excl;
    endfunction

    // One full transaction; inputs change just after the falling edge.
    task automatic run_txn(input logic [TAG_W-1:0] tag, input bit ex, input int inh,
                           input int mdel, input bit d, input int mw, input int cdel,
                           input bit shr, input int gdel);
        @(negedge clk);
        req_valid = 1'b1; req_tag = tag; req_excl = ex;
        #1 chk(busy == 1'b0, "R6 idle before start", int'(busy), 0);
        for (int i = 0; i < inh; i++) begin
            @(negedge clk);
            req_valid = 1'b0; snp_inhibit = 1'b1; snp_dirty = 1'b0;
            snp_shared = (i == 0) && shr; mem_ready = (i >= mdel);
            #1 chk(!bus_req && !mem_abort, "R2 inhibit holds", int'({bus_req, mem_abort}), 0);
        end
        @(negedge clk);
        req_valid = 1'b0; snp_inhibit = 1'b0; snp_dirty = d;
        snp_shared = (inh == 0) && shr; mem_ready = !d && (mw == 0);
        if (d) begin
            #1 chk(mem_abort == 1'b1, "R3 abort on dirty", int'(mem_abort), 1);
            for (int j = 0; j < cdel; j++) begin
                @(negedge clk);
                snp_dirty = 1'b0; snp_shared = 1'b0; cache_ready = 1'b0;
                #1 chk(!bus_req && !mem_abort, "R3 wait owner", int'({bus_req, mem_abort}), 0);
            end
            @(negedge clk);
            snp_dirty = 1'b0; snp_shared = 1'b0; cache_ready = 1'b1;
            #1 chk(!bus_req, "R3 no req before owner ready", int'(bus_req), 0);
        end else begin
            #1 chk(mem_abort == 1'b0, "R4 no abort", int'(mem_abort), 0);
            for (int j = 0; j < mw; j++) begin
                @(negedge clk);
                snp_shared = 1'b0; mem_ready = (j == mw - 1);
                #1 chk(!bus_req && !mem_abort, "R4 wait memory", int'({bus_req, mem_abort}), 0);
            end
        end
        for (int j = 0; j < gdel; j++) begin
            @(negedge clk);
            snp_dirty = 1'b0; snp_shared = 1'b0; mem_ready = 1'b0; cache_ready = 1'b0;
            bus_grant = 1'b0;
            #1 chk(bus_req && !rsp_valid, "R5 request held", int'({bus_req, rsp_valid}), 2);
        end
        @(negedge clk);
        snp_dirty = 1'b0; snp_shared = 1'b0; mem_ready = 1'b0; cache_ready = 1'b0;
        bus_grant = 1'b1;
        #1 chk(bus_req == 1'b1, "R5 request at grant", int'(bus_req), 1);
        for (int k = 0; k < NBEAT; k++) begin
            @(negedge clk);
            bus_grant = 1'b0; req_valid = (k == 1); req_tag = ~tag; req_excl = 1'b0;
            #1;
            chk(rsp_valid && rsp_beat == 2'(k), "R6 beat", int'(rsp_beat), k);
            chk(rsp_tag == tag, "R7 tag (R10 after k=1)", int'(rsp_tag), int'(tag));
            chk(rsp_src == d && rsp_dirty == d, "R7 source", int'(rsp_src), int'(d));
            chk(rsp_shared == shr, "R7 shared", int'(rsp_shared), int'(shr));
            chk(tag_release == (k == NBEAT - 1), "R8 release", int'(tag_release), int'(k == NBEAT - 1));
            chk(mem_sink == exp_sink(d, ex), "R9 sink", int'(mem_sink), int'(exp_sink(d, ex)));
            chk(grab_ok == !ex, "R9 grab", int'(grab_ok), int'(!ex));
        end
        @(negedge clk);
        req_valid = 1'b0;
        #1 chk(!rsp_valid && busy && !tag_release, "R6 turnaround",
               int'({rsp_valid, busy, tag_release}), 2);
        @(negedge clk);
        #1 chk(!busy && !rsp_valid, "R10 no restart after ignored request",
               int'({busy, rsp_valid}), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #1 chk(!busy && !bus_req && !rsp_valid && !mem_abort && !tag_release, "R1 reset",
               int'({busy, bus_req, rsp_valid, mem_abort, tag_release}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk(!busy && !bus_req, "R1 after release", int'({busy, bus_req}), 0);
        // Directed corner cases
        run_txn(3'd5, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0, 0);  // no inhibit, memory ready, instant grant
        run_txn(3'd2, 1'b0, 3, 0, 1'b0, 0, 0, 1'b1, 1);  // memory ready under inhibit
        run_txn(3'd7, 1'b0, 2, 9, 1'b1, 0, 0, 1'b1, 0);  // dirty owner, ready at once
        run_txn(3'd1, 1'b1, 1, 9, 1'b1, 0, 3, 1'b0, 2);  // exclusive from dirty owner
        run_txn(3'd4, 1'b1, 0, 0, 1'b0, 2, 0, 1'b0, 0);  // exclusive from memory
        // Constrained random
        for (int n = 0; n < 60; n++) begin
            run_txn(3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                    int'($urandom_range(0, 4)), int'($urandom_range(0, 5)),
                    1'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
                    int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                    int'($urandom_range(0, 3)));
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule